// File: doc/BRIEF.md
# Frame Schedule Walker

This block walks one frame's worth of transfer schedule held in shared memory. A frame-start pulse makes it read a single entry from a frame list, at the entry that the frame index selects. From that entry it follows a chain of link words through queue heads and transfer descriptors. Each transfer descriptor whose active flag is set is handed to an external transaction executor, and the walker waits for the executor's completion status. A queue head stands for an ordered queue of descriptors. When a descriptor inside a queue completes successfully, the walker stores that descriptor's own link word into the queue head's element word, so the queue advances. The next frame then starts from the new top element.

Every link word uses the same format. Bits 31:4 hold a 16-byte-aligned byte pointer. Bits 3:2 are reserved, except that bit 2 of a descriptor's link word chooses how the queue is walked. Bit 1 marks the target as a queue head (1) or a descriptor (0). Bit 0 marks the link as terminated. A queue head has two words: a horizontal link at offset 0 and an element link at offset 4. A descriptor also has two words used here: its link at offset 0 and a status word at offset 4. Bit 23 of the status word is the active flag.

Memory requests use a valid/ready handshake. The walker raises `mem_valid` and holds the address, the write flag and the write data unchanged until `mem_ready` is sampled high. A write completes at that handshake. A read returns its data later, on a one-cycle `mem_rvalid` pulse. Only one request is ever outstanding, and the walker accepts a read response on any cycle. Executor requests also hold: `exe_valid` and `exe_td` stay unchanged until the one-cycle `exe_done` pulse, and `exe_ok` is sampled together with that pulse.

Top module: `sched_walker`

## Requirements
- R1: A frame-start pulse while the walker is idle raises `busy` on the next cycle. The first request is then a read of byte address `list_base + 4*frame_idx`. A frame-start pulse while `busy` is high is ignored and changes no access.
- R2: If the frame-list entry has bit 0 set, the frame ends after that single read and `busy` falls. While `busy` is low, neither `mem_valid` nor `exe_valid` is asserted.
- R3: A link with bit 0 clear is followed to the byte pointer in its bits 31:4. If bit 1 is set, the walker reads that pointer and then pointer+4 as a queue head. If bit 1 is clear, it reads pointer and pointer+4 as a descriptor.
- R4: A descriptor whose status word has bit 23 clear is not executed. No executor request is made for it.
- R5: An active descriptor produces an executor request with `exe_td` equal to the descriptor's byte address. The request is held stable until `exe_done`, and no memory request is made while it is pending.
- R6: A descriptor reached through a queue head's element link that completes with `exe_ok`=1 causes a write of its link word to the queue head's address+4. That write is the next memory request after the completion.
- R7: A descriptor that completes with `exe_ok`=0 inside a queue causes no write. The walk continues at the queue head's horizontal link.
- R8: After a successful descriptor whose link has bit 2 clear (breadth mode), the walk continues at the owning queue head's horizontal link.
- R9: After a successful descriptor whose link has bit 2 set (depth mode), the walk takes that link as the queue's next element in the same queue. Each further success writes back to the same queue head.
- R10: An element link with bit 0 set (empty queue) sends the walk to the horizontal link. A horizontal link with bit 0 set ends the frame.
- R11: An element link with bit 1 set enters the inner queue head as the new queue context. Write-backs then go only to the inner head, the outer head's element word is never written, and the walk continues at the inner head's horizontal link.
- R12: A descriptor reached through a horizontal or frame-list link is executed without any write-back. Its link is followed whatever its completion status.
- R13: `mem_valid` held low by `mem_ready`=0 keeps `mem_addr`, `mem_write` and `mem_wdata` stable on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse that starts a frame walk |
| frame_idx | input | IDX_W | Frame index selecting the frame-list entry |
| list_base | input | 32 | Byte base address of the frame list |
| busy | output | 1 | High while a frame walk is in progress |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_write | output | 1 | 1 = write request, 0 = read request |
| mem_addr | output | 30 | Word address of the request |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | One-cycle read-data strobe |
| mem_rdata | input | 32 | Read data |
| exe_valid | output | 1 | Executor request, held until done |
| exe_td | output | 32 | Byte address of the descriptor to execute |
| exe_done | input | 1 | One-cycle completion pulse from the executor |
| exe_ok | input | 1 | Completion status, 1 = success, valid with exe_done |

## Verification
A second frame-start pulse can arrive in the same cycle that a memory request is being stalled by `mem_ready`. The bench provokes this by sending a pulse with a different index a few cycles into a depth-mode walk, while the memory model withdraws ready on a pseudo-random pattern. The scoreboard expects the unchanged access stream of the first frame, so any read of the second index, or any altered or repeated request, shows up as a mismatch. Every memory handshake and every executor completion is compared in order against sequences derived from the requirements. After each frame the bench inspects the stored element words to confirm that queues advance, or stay put, as expected.

// File: rtl/sched_walk_pkg.sv
package sched_walk_pkg;

  localparam int LINK_W    = 32;
  localparam int LNK_DEPTH = 2;   // depth/breadth select inside a descriptor link
  localparam int LNK_QH    = 1;   // target is a queue head
  localparam int LNK_TERM  = 0;   // pointer invalid

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LIST,   // read frame-list entry
    ST_DISP,   // decide where the current link leads
    ST_QH0,    // read queue head horizontal word
    ST_QH1,    // read queue head element word
    ST_TD0,    // read descriptor link word
    ST_TD1,    // read descriptor status word
    ST_EXEC,   // wait on executor
    ST_WB,     // write element word back
    ST_NEXT    // choose follow-on link
  } walk_st_e;

  typedef struct packed {
    logic [LINK_W-1:0] ptr;
    logic              is_qh;
    logic              term;
  } link_t;

endpackage

// File: rtl/sched_link_dec.sv
module sched_link_dec
  import sched_walk_pkg::*;
(
  input  logic [LINK_W-1:0] link_word,
  output link_t             fields
);
  assign fields.ptr   = link_word & ~{{(LINK_W-4){1'b0}}, 4'hF};
  assign fields.is_qh = link_word[LNK_QH];
  assign fields.term  = link_word[LNK_TERM];
endmodule

// File: rtl/sched_mem_port.sv
module sched_mem_port #(
  parameter int AW = 30,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          cmd_write,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          cmd_done,
  output logic [DW-1:0] cmd_rdata,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata
);
  logic waiting;

  assign mem_valid = cmd_valid && !waiting;
  assign mem_write = cmd_write;
  assign mem_addr  = cmd_addr;
  assign mem_wdata = cmd_wdata;
  assign cmd_rdata = mem_rdata;
  assign cmd_done  = (mem_valid && mem_ready && cmd_write) || (waiting && mem_rvalid);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waiting <= 1'b0;
    end else if (mem_valid && mem_ready && !cmd_write) begin
      waiting <= 1'b1;
    end else if (waiting && mem_rvalid) begin
      waiting <= 1'b0;
    end
  end

  // R13: a stalled request keeps its content
  assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                   $stable(mem_write) && $stable(mem_wdata)));

endmodule

// File: rtl/sched_walker.sv
module sched_walker
  import sched_walk_pkg::*;
#(
  parameter int IDX_W   = 10,
  parameter int ACT_BIT = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [IDX_W-1:0]  frame_idx,
  input  logic [31:0]       list_base,
  output logic              busy,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [29:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              exe_valid,
  output logic [31:0]       exe_td,
  input  logic              exe_done,
  input  logic              exe_ok
);
  localparam int WORD_AW = LINK_W - 2;

  walk_st_e          st;
  logic [IDX_W-1:0]  idx_q;
  logic [LINK_W-1:0] base_q;
  logic [LINK_W-1:0] cur_link;
  logic              vert;      // cur_link came from an element link
  logic [LINK_W-1:0] qh_addr;   // cached queue context
  logic [LINK_W-1:0] qh_horiz;
  logic              in_q;
  logic [LINK_W-1:0] td_addr;
  logic [LINK_W-1:0] td_link;
  logic              run_ok;

  link_t cl;
  sched_link_dec u_cur_dec (.link_word(cur_link), .fields(cl));

  logic              cmd_valid;
  logic              cmd_write;
  logic [LINK_W-1:0] cmd_byte;
  logic              cmd_done;
  logic [LINK_W-1:0] cmd_rdata;

  always_comb begin
    cmd_valid = 1'b1;
    cmd_write = 1'b0;
    cmd_byte  = '0;
    unique case (st)
      ST_LIST: cmd_byte = base_q + {{(LINK_W-IDX_W-2){1'b0}}, idx_q, 2'b00};
      ST_QH0:  cmd_byte = qh_addr;
      ST_QH1:  cmd_byte = qh_addr + 32'd4;
      ST_TD0:  cmd_byte = td_addr;
      ST_TD1:  cmd_byte = td_addr + 32'd4;
      ST_WB: begin
        cmd_byte  = qh_addr + 32'd4;
        cmd_write = 1'b1;
      end
      default: cmd_valid = 1'b0;
    endcase
  end

  sched_mem_port #(.AW(WORD_AW), .DW(LINK_W)) u_mem_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_write (cmd_write),
    .cmd_addr  (cmd_byte[LINK_W-1:2]),
    .cmd_wdata (td_link),
    .cmd_done  (cmd_done),
    .cmd_rdata (cmd_rdata),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_write (mem_write),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rvalid(mem_rvalid),
    .mem_rdata (mem_rdata)
  );

  assign busy      = (st != ST_IDLE);
  assign exe_valid = (st == ST_EXEC);
  assign exe_td    = td_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      idx_q    <= '0;
      base_q   <= '0;
      cur_link <= '0;
      vert     <= 1'b0;
      qh_addr  <= '0;
      qh_horiz <= '0;
      in_q     <= 1'b0;
      td_addr  <= '0;
      td_link  <= '0;
      run_ok   <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (frame_start) begin
          idx_q  <= frame_idx;
          base_q <= list_base;
          st     <= ST_LIST;
        end
        ST_LIST: if (cmd_done) begin
          cur_link <= cmd_rdata;
          vert     <= 1'b0;
          st       <= ST_DISP;
        end
        ST_DISP: begin
          if (cl.term) begin
            if (vert) begin          // empty queue: go sideways
              cur_link <= qh_horiz;
              vert     <= 1'b0;
            end else begin           // end of frame
              st <= ST_IDLE;
            end
          end else if (cl.is_qh) begin   // new (possibly nested) context
            qh_addr <= cl.ptr;
            st      <= ST_QH0;
          end else begin
            td_addr <= cl.ptr;
            in_q    <= vert;
            st      <= ST_TD0;
          end
        end
        ST_QH0: if (cmd_done) begin
          qh_horiz <= cmd_rdata;
          st       <= ST_QH1;
        end
        ST_QH1: if (cmd_done) begin
          cur_link <= cmd_rdata;
          vert     <= 1'b1;
          st       <= ST_DISP;
        end
        ST_TD0: if (cmd_done) begin
          td_link <= cmd_rdata;
          st      <= ST_TD1;
        end
        ST_TD1: if (cmd_done) begin
          if (cmd_rdata[ACT_BIT]) begin
            st <= ST_EXEC;
          end else begin
            run_ok <= 1'b0;
            st     <= ST_NEXT;
          end
        end
        ST_EXEC: if (exe_done) begin
          run_ok <= exe_ok;
          st     <= (exe_ok && in_q) ? ST_WB : ST_NEXT;
        end
        ST_WB: if (cmd_done) st <= ST_NEXT;
        ST_NEXT: begin
          if (!in_q) begin
            cur_link <= td_link;
            vert     <= 1'b0;
          end else if (run_ok && td_link[LNK_DEPTH]) begin
            cur_link <= td_link;
            vert     <= 1'b1;
          end else begin
            cur_link <= qh_horiz;
            vert     <= 1'b0;
          end
          st <= ST_DISP;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R1: a walk always opens with a read
  assert_first_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (mem_valid && !mem_write));

  // R2: nothing leaves the block while idle
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_valid && !exe_valid));

  // R5: executor request held until done
  assert_exe_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (exe_valid && !exe_done) |=> (exe_valid && $stable(exe_td)));

  // R5: no memory traffic while executing
  assert_exe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(exe_valid && mem_valid));

  // R6: write-backs only ever target an element word (offset 4 of a head)
  assert_wb_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_write) |-> (mem_addr[1:0] == 2'b01));

  // R7: a write-back follows directly on a successful completion
  assert_wb_after_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_valid && mem_write) |-> $past(exe_done && exe_ok));

endmodule

// File: tb/test_sched_walker.sv
`timescale 1ns/1ps
module test_sched_walker;

  localparam logic [31:0] ACT  = 32'h0080_0000;
  localparam logic [31:0] BASE = 32'h0000_0200;

  typedef struct packed {
    logic [1:0]  k;   // 0 read, 1 write, 2 execute
    logic [31:0] a;
    logic [31:0] d;
  } ev_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic [9:0]  frame_idx = '0;
  logic        busy;
  logic        mem_valid, mem_write;
  logic        mem_ready = 1'b0;
  logic [29:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        exe_valid;
  logic [31:0] exe_td;
  logic        exe_done = 1'b0;
  logic        exe_ok = 1'b0;

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] mem [0:255];
  logic        ok_tab [0:15];
  logic [7:0]  lfsr = 8'hA5;
  logic [1:0]  lat = '0;
  logic [31:0] rdq = '0;
  logic [1:0]  ecnt = '0;

  ev_t   exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  sched_walker i_sched_walker (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_idx(frame_idx),
    .list_base(BASE), .busy(busy),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .exe_valid(exe_valid), .exe_td(exe_td),
    .exe_done(exe_done), .exe_ok(exe_ok)
  );

  // memory model with pseudo-random back-pressure and 1..2 cycle read latency
  always @(posedge clk) begin
    lfsr       <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_ready  <= lfsr[0] | lfsr[2];
    mem_rvalid <= 1'b0;
    if (lat != 0) begin
      if (lat == 1) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= rdq;
      end
      lat <= lat - 1;
    end
    if (mem_valid && mem_ready) begin
      if (mem_write) mem[mem_addr[7:0]] <= mem_wdata;
      else begin
        rdq <= mem[mem_addr[7:0]];
        lat <= lfsr[1] ? 2'd2 : 2'd1;
      end
    end
  end

  // executor model: completes three cycles after a request appears
  always @(posedge clk) begin
    exe_done <= 1'b0;
    if (exe_valid && !exe_done) begin
      if (ecnt == 2) begin
        exe_done <= 1'b1;
        exe_ok   <= ok_tab[exe_td[7:4]];
        ecnt     <= '0;
      end else ecnt <= ecnt + 1;
    end
  end

  task automatic chk(input bit cond, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s: %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  task automatic expect_ev(input logic [1:0] k, input logic [31:0] a,
                           input logic [31:0] d, input string tag);
    ev_t e;
    e.k = k; e.a = a; e.d = d;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic rd(input logic [31:0] a, input string tag);
    expect_ev(2'd0, a, 32'h0, tag);
  endtask
  task automatic wr(input logic [31:0] a, input logic [31:0] d, input string tag);
    expect_ev(2'd1, a, d, tag);
  endtask
  task automatic ex(input logic [31:0] a, input string tag);
    expect_ev(2'd2, a, 32'h0, tag);
  endtask

  task automatic compare(input ev_t got);
    ev_t   e;
    string t;
    if (exp_q.size() == 0) begin
      chk(1'b0, "R7", $sformatf("unexpected event kind %0d", got.k), got.a, 32'h0);
    end else begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(got.k == e.k, t, "event kind", {30'h0, got.k}, {30'h0, e.k});
      chk(got.a == e.a, t, "event address", got.a, e.a);
      if (e.k == 2'd1) chk(got.d == e.d, t, "write data", got.d, e.d);
    end
  endtask

  // monitor: sampled on the falling edge, the handshake completes on the next rise
  always @(negedge clk) begin
    ev_t g;
    if (rst_n) begin
      if (mem_valid && mem_ready) begin
        g.k = mem_write ? 2'd1 : 2'd0;
        g.a = {mem_addr, 2'b00};
        g.d = mem_write ? mem_wdata : 32'h0;
        compare(g);
      end
      if (exe_valid && exe_done) begin
        g.k = 2'd2; g.a = exe_td; g.d = 32'h0;
        compare(g);
      end
    end
  end

  task automatic run_frame(input logic [9:0] idx, input bit poke);
    int n;
    @(negedge clk);
    frame_idx   = idx;
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    chk(busy == 1'b1, "R1", "busy after frame start", {31'h0, busy}, 32'h1);
    if (poke) begin
      repeat (4) @(negedge clk);
      frame_idx   = 10'd1;       // must be ignored (R1)
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
    end
    n = 0;
    while (busy && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(!busy, "R2", "walk finished", {31'h0, busy}, 32'h0);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R3", "expected events left", exp_q.size(), 32'h0);
    exp_q.delete();
    tag_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run hung actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h1;
    for (int i = 0; i < 16; i++) ok_tab[i] = 1'b1;
    // frame list at 0x200
    mem[128] = 32'h1;      // idx0: empty frame
    mem[129] = 32'h42;     // idx1: QH A
    mem[130] = 32'h42;     // idx2: QH A
    mem[131] = 32'h100;    // idx3: TD1 directly
    mem[132] = 32'h42;     // idx4: QH A
    // QH A @0x40, QH B @0x60, QH C @0x80
    mem[16] = 32'h62;  mem[17] = 32'h100;
    mem[24] = 32'h1;   mem[25] = 32'h1;
    mem[32] = 32'h1;   mem[33] = 32'h140;
    // TDs @0x100..0x140
    mem[64] = 32'h110; mem[65] = ACT;
    mem[68] = 32'h1;   mem[69] = ACT;
    mem[72] = 32'h134; mem[73] = ACT;
    mem[76] = 32'h1;   mem[77] = ACT;
    mem[80] = 32'h1;   mem[81] = ACT;

    repeat (4) @(negedge clk);
    chk(!busy && !mem_valid && !exe_valid, "R2", "reset state quiet",
        {29'h0, busy, mem_valid, exe_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // empty frame
    rd(32'h200, "R2");
    run_frame(10'd0, 1'b0);

    // descriptors outside any queue, first fails
    ok_tab[0] = 1'b0;
    rd(32'h20C, "R1"); rd(32'h100, "R3"); rd(32'h104, "R3"); ex(32'h100, "R12");
    rd(32'h110, "R12"); rd(32'h114, "R12"); ex(32'h110, "R12");
    run_frame(10'd3, 1'b0);
    chk(mem[17] == 32'h100, "R12", "element word untouched", mem[17], 32'h100);

    // breadth queue, success advances
    ok_tab[0] = 1'b1;
    rd(32'h204, "R1"); rd(32'h40, "R3"); rd(32'h44, "R3"); rd(32'h100, "R3"); rd(32'h104, "R3");
    ex(32'h100, "R5"); wr(32'h44, 32'h110, "R6"); rd(32'h60, "R8"); rd(32'h64, "R8");
    run_frame(10'd1, 1'b0);
    chk(mem[17] == 32'h110, "R6", "queue advanced", mem[17], 32'h110);

    // next frame picks up the new top element
    rd(32'h204, "R1"); rd(32'h40, "R6"); rd(32'h44, "R6"); rd(32'h110, "R6"); rd(32'h114, "R6");
    ex(32'h110, "R6"); wr(32'h44, 32'h1, "R6"); rd(32'h60, "R10"); rd(32'h64, "R10");
    run_frame(10'd1, 1'b0);

    // depth mode, with an ignored frame start during the walk
    mem[17] = 32'h124;
    rd(32'h208, "R1"); rd(32'h40, "R3"); rd(32'h44, "R3"); rd(32'h120, "R9"); rd(32'h124, "R9");
    ex(32'h120, "R9"); wr(32'h44, 32'h134, "R9"); rd(32'h130, "R9"); rd(32'h134, "R9");
    ex(32'h130, "R9"); wr(32'h44, 32'h1, "R9"); rd(32'h60, "R10"); rd(32'h64, "R10");
    run_frame(10'd2, 1'b1);

    // failure: no advance, go sideways
    mem[17] = 32'h124;
    ok_tab[2] = 1'b0;
    rd(32'h208, "R1"); rd(32'h40, "R3"); rd(32'h44, "R3"); rd(32'h120, "R7"); rd(32'h124, "R7");
    ex(32'h120, "R7"); rd(32'h60, "R7"); rd(32'h64, "R7");
    run_frame(10'd2, 1'b0);
    chk(mem[17] == 32'h124, "R7", "element word after failure", mem[17], 32'h124);

    // inactive descriptor skipped
    ok_tab[2] = 1'b1;
    mem[73] = 32'h0;
    rd(32'h208, "R1"); rd(32'h40, "R3"); rd(32'h44, "R3"); rd(32'h120, "R4"); rd(32'h124, "R4");
    rd(32'h60, "R4"); rd(32'h64, "R4");
    run_frame(10'd2, 1'b0);
    chk(mem[17] == 32'h124, "R4", "element word after skip", mem[17], 32'h124);
    mem[73] = ACT;

    // nested queue head
    mem[17] = 32'h82;
    rd(32'h210, "R1"); rd(32'h40, "R11"); rd(32'h44, "R11"); rd(32'h80, "R11"); rd(32'h84, "R11");
    rd(32'h140, "R11"); rd(32'h144, "R11"); ex(32'h140, "R11"); wr(32'h84, 32'h1, "R11");
    run_frame(10'd4, 1'b0);
    chk(mem[17] == 32'h82, "R11", "outer element word kept", mem[17], 32'h82);
    chk(mem[33] == 32'h1, "R11", "inner element word advanced", mem[33], 32'h1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule